// File: doc/BRIEF.md
# Sync Reference Selector and Loss-of-Reference Monitor

This block sits in front of a video clock phase comparator. It receives two pairs of horizontal and vertical sync inputs, one pair per reference port. It chooses one port, turns each input into an active-high event according to that input's own polarity setting, and passes single-cycle edge pulses for the chosen port downstream. The pin and mode inputs are resolved through fixed precedence rules. The resolved port and the resolved operating mode (free run or locked to the reference) are reported as registered outputs.

The block also watches the horizontal edges of the chosen port. Each edge opens a window of the programmed line period plus a fixed tolerance. When a window closes with no edge, one missed line is counted. Once the missed-line count goes past a 3-bit limit, the reference is declared lost. Reference-good is raised only after two consecutive horizontal edges have arrived with no window expiry between them. The same rule applies after reset, after a loss, and after every change of port. A separate loss flag is always the inverse of reference-good.

Top module: `sync_ref_monitor`

## Requirements
- R1: After reset, `ref_ok_o`=0, `ref_lost_o`=1, `lock_mode_o`=0 (free run), `port_sel_o`=0 (port A), and no edge pulses appear while the sync inputs are idle.
- R2: The port is chosen as follows. When `sel_force_i`=1, `sel_reg_i` chooses. Otherwise, when `sel_reg_en_i`=1, `sel_reg_i` chooses. Otherwise the synchronized `src_pin_i` chooses. Value 0 selects port A and 1 selects port B. A change on the pin appears on `port_sel_o` three clock edges later.
- R3: When `mode_reg_en_i`=1, `mode_reg_i` sets `lock_mode_o` (0 free run, 1 locked). When `mode_reg_en_i`=0, the synchronized `lock_pin_i` sets it and `mode_reg_i` has no effect.
- R4: Each sync input has its own polarity bit (0 = active low, 1 = active high). The inactive-to-active transition of a selected input produces a one-cycle pulse on `h_edge_o`/`v_edge_o` at the third clock edge after the transition. The return to the inactive level produces no pulse.
- R5: Transitions on the unselected port produce no pulses on `h_edge_o` or `v_edge_o`.
- R6: `ref_ok_o` rises only on the cycle after an `h_edge_o` pulse. It requires two consecutive horizontal edges with no window expiry between them. The window is `line_period_i` + TOL_CYC clock cycles long.
- R7: With limit N on `miss_limit_i`, reference loss is declared at the (N+1)-th consecutive window expiry. Every horizontal edge clears the missed-line count.
- R8: `ref_lost_o` is always the inverse of `ref_ok_o`.
- R9: A change of the resolved port clears `ref_ok_o` and the missed-line count in the same cycle that `port_sel_o` changes. The new port must then qualify again under R6.
- R10: With no pulses at the selected port, `ref_ok_o` stays 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_a_i | input | 1 | Port A horizontal sync (asynchronous) |
| vsync_a_i | input | 1 | Port A vertical sync (asynchronous) |
| hsync_b_i | input | 1 | Port B horizontal sync (asynchronous) |
| vsync_b_i | input | 1 | Port B vertical sync (asynchronous) |
| src_pin_i | input | 1 | External port select pin (asynchronous) |
| lock_pin_i | input | 1 | External mode pin (asynchronous) |
| sel_force_i | input | 1 | Hard override: register bit always chooses the port |
| sel_reg_en_i | input | 1 | Register control of port choice |
| sel_reg_i | input | 1 | Register port choice |
| mode_reg_en_i | input | 1 | Register control of mode |
| mode_reg_i | input | 1 | Register mode choice |
| hpol_a_i | input | 1 | Polarity of port A horizontal sync |
| vpol_a_i | input | 1 | Polarity of port A vertical sync |
| hpol_b_i | input | 1 | Polarity of port B horizontal sync |
| vpol_b_i | input | 1 | Polarity of port B vertical sync |
| miss_limit_i | input | 3 | Missed lines tolerated before loss |
| line_period_i | input | PERIOD_W | Expected line period in clock cycles |
| h_edge_o | output | 1 | Selected horizontal active-edge pulse |
| v_edge_o | output | 1 | Selected vertical active-edge pulse |
| ref_ok_o | output | 1 | Reference good |
| ref_lost_o | output | 1 | Loss of reference flag |
| lock_mode_o | output | 1 | Resolved mode (1 = locked) |
| port_sel_o | output | 1 | Resolved port (1 = port B) |

## Verification
The hardest behaviour to reach is the miss counter sitting one step short of the limit and then being cleared by a late edge. A line stream must first qualify the reference. After that, line gaps are stretched to just over one window but under two, so each gap costs exactly one miss. With a limit of 1, a counter that failed to clear would declare loss. The exact expiry on which loss is declared is probed by stopping the lines and sampling a few cycles before and after the computed expiry edge, for limits 0 and 2.

// File: rtl/sync_ref_pkg.sv
// Shared types for the sync reference monitor.
package sync_ref_pkg;
    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;

    typedef struct packed {
        logic h;
        logic v;
    } sync_pair_t;
endpackage

// File: rtl/sync_ref_cdc.sv
// Multi-stage synchronizer for a bundle of independent asynchronous bits.
// Assumes each bit is a level or a pulse long enough to be sampled; no
// cross-bit coherence is provided.
module sync_ref_cdc #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sync_ref_edge.sv
// Polarity correction and active-edge detection for one H/V sync pair.
// Assumes synchronized inputs. The history flop resets to the active level,
// so no false edge is produced when reset releases.
module sync_ref_edge
    import sync_ref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_i,
    input  logic       v_i,
    input  logic       hpol_i,
    input  logic       vpol_i,
    output sync_pair_t rise_o
);
    sync_pair_t norm;
    sync_pair_t prev_q;

    // Map each input to active-high using its polarity bit.
    always_comb begin
        norm.h = h_i ~^ hpol_i;
        norm.v = v_i ~^ vpol_i;
    end

    // Remember the previous normalized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= norm;
    end

    // Inactive-to-active transition flags.
    always_comb begin
        rise_o.h = norm.h & ~prev_q.h;
        rise_o.v = norm.v & ~prev_q.v;
    end
endmodule

// File: rtl/sync_ref_loss.sv
// Missing-line detector and reference qualification.
// A window of period+TOL cycles follows each edge. Each expiry is one miss,
// and loss is declared when misses exceed the limit. Qualification needs two
// edges with no expiry between them. A restart clears all state.
module sync_ref_loss #(
    parameter int PERIOD_W = 16,
    parameter int TOL_CYC  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_i,
    input  logic                restart_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [2:0]          limit_i,
    output logic                ok_o,
    output logic                lost_o
);
    localparam int TW = PERIOD_W + 1;

    logic [TW-1:0] timer_q;
    logic [TW-1:0] win;
    logic [2:0]    miss_q;
    logic          armed_q;
    logic          expire;

    // Window length and expiry detection.
    always_comb begin
        win    = {1'b0, period_i} + TW'(TOL_CYC);
        expire = (timer_q >= win);
    end

    // Track line timing, misses and reference status.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            timer_q <= '0;
            miss_q  <= '0;
            armed_q <= 1'b0;
            ok_o    <= 1'b0;
            lost_o  <= 1'b1;
        end else if (edge_i) begin
            timer_q <= '0;
            miss_q  <= '0;
            armed_q <= 1'b1;
            if (armed_q) begin
                ok_o   <= 1'b1;
                lost_o <= 1'b0;
            end
        end else if (expire) begin
            timer_q <= '0;
            armed_q <= 1'b0;
            if (miss_q >= limit_i) begin
                ok_o   <= 1'b0;
                lost_o <= 1'b1;
            end else begin
                miss_q <= miss_q + 3'd1;
            end
        end else begin
            timer_q <= timer_q + TW'(1);
        end
    end
endmodule

// File: rtl/sync_ref_monitor.sv
// Top of the sync reference selector and loss monitor.
// Synchronizes the asynchronous syncs and pins, resolves port and mode
// precedence, forwards the chosen port's edges and runs the loss detector.
// Assumes register-side inputs are already synchronous to clk.
module sync_ref_monitor
    import sync_ref_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int TOL_CYC  = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_a_i,
    input  logic                vsync_a_i,
    input  logic                hsync_b_i,
    input  logic                vsync_b_i,
    input  logic                src_pin_i,
    input  logic                lock_pin_i,
    input  logic                sel_force_i,
    input  logic                sel_reg_en_i,
    input  logic                sel_reg_i,
    input  logic                mode_reg_en_i,
    input  logic                mode_reg_i,
    input  logic                hpol_a_i,
    input  logic                vpol_a_i,
    input  logic                hpol_b_i,
    input  logic                vpol_b_i,
    input  logic [2:0]          miss_limit_i,
    input  logic [PERIOD_W-1:0] line_period_i,
    output logic                h_edge_o,
    output logic                v_edge_o,
    output logic                ref_ok_o,
    output logic                ref_lost_o,
    output logic                lock_mode_o,
    output logic                port_sel_o
);
    localparam int NPORT = 2;
    localparam int NSYNC = 2 * NPORT + 2;

    logic [NSYNC-1:0] raw;
    logic [NSYNC-1:0] syn;
    logic [NPORT-1:0] pol_h;
    logic [NPORT-1:0] pol_v;
    sync_pair_t       rise [NPORT];
    port_e            sel_next;
    port_e            sel_q;
    logic             mode_next;
    logic             restart;

    assign raw   = {lock_pin_i, src_pin_i, vsync_b_i, hsync_b_i, vsync_a_i, hsync_a_i};
    assign pol_h = {hpol_b_i, hpol_a_i};
    assign pol_v = {vpol_b_i, vpol_a_i};

    sync_ref_cdc #(.W(NSYNC), .STAGES(STAGES)) u_cdc (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    // One edge detector per reference port.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        sync_ref_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .h_i    (syn[2*p]),
            .v_i    (syn[2*p+1]),
            .hpol_i (pol_h[p]),
            .vpol_i (pol_v[p]),
            .rise_o (rise[p])
        );
    end

    // Resolve port and mode precedence.
    always_comb begin
        if (sel_force_i || sel_reg_en_i) sel_next = port_e'(sel_reg_i);
        else                             sel_next = port_e'(syn[2*NPORT]);
        mode_next = mode_reg_en_i ? mode_reg_i : syn[2*NPORT+1];
        restart   = (sel_next != sel_q);
    end

    // Register resolved controls and forward the chosen port's edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= PORT_A;
            lock_mode_o <= 1'b0;
            h_edge_o    <= 1'b0;
            v_edge_o    <= 1'b0;
        end else begin
            sel_q       <= sel_next;
            lock_mode_o <= mode_next;
            h_edge_o    <= rise[sel_q].h;
            v_edge_o    <= rise[sel_q].v;
        end
    end

    assign port_sel_o = sel_q;

    sync_ref_loss #(.PERIOD_W(PERIOD_W), .TOL_CYC(TOL_CYC)) u_loss (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (h_edge_o),
        .restart_i (restart),
        .period_i  (line_period_i),
        .limit_i   (miss_limit_i),
        .ok_o      (ref_ok_o),
        .lost_o    (ref_lost_o)
    );
endmodule

// File: rtl/sync_ref_monitor_chk.sv
// Property checker for sync_ref_monitor, attached by bind.
module sync_ref_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic h_edge_o,
    input logic v_edge_o,
    input logic ref_ok_o,
    input logic ref_lost_o,
    input logic lock_mode_o,
    input logic port_sel_o
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!ref_ok_o && !lock_mode_o && !port_sel_o)); // R1

    AST_H_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_edge_o |=> !h_edge_o); // R4

    AST_V_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        v_edge_o |=> !v_edge_o); // R4

    AST_OK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok_o) |-> $past(h_edge_o)); // R6

    AST_LOST_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost_o == !ref_ok_o); // R8

    AST_PORT_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel_o != $past(port_sel_o)) |-> !ref_ok_o); // R9
endmodule

bind sync_ref_monitor sync_ref_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_edge_o    (h_edge_o),
    .v_edge_o    (v_edge_o),
    .ref_ok_o    (ref_ok_o),
    .ref_lost_o  (ref_lost_o),
    .lock_mode_o (lock_mode_o),
    .port_sel_o  (port_sel_o)
);

// File: tb/sync_ref_monitor_tb.sv
// Directed bench for sync_ref_monitor; TOL_CYC=4, line period 20.
module sync_ref_monitor_tb;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_a_i = 0, vsync_a_i = 0, hsync_b_i = 0, vsync_b_i = 0;
    logic src_pin_i = 0, lock_pin_i = 0;
    logic sel_force_i = 0, sel_reg_en_i = 0, sel_reg_i = 0;
    logic mode_reg_en_i = 0, mode_reg_i = 0;
    logic hpol_a_i = 1, vpol_a_i = 1, hpol_b_i = 1, vpol_b_i = 1;
    logic [2:0] miss_limit_i = 3'd2;
    logic [PW-1:0] line_period_i = 16'd20;
    logic h_edge_o, v_edge_o, ref_ok_o, ref_lost_o, lock_mode_o, port_sel_o;

    int n_tests = 0;
    int n_fail  = 0;
    int h_cnt   = 0;
    int v_cnt   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    sync_ref_monitor #(.PERIOD_W(PW), .TOL_CYC(4)) u_dut (.*);

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (h_edge_o) h_cnt++;
        if (v_edge_o) v_cnt++;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {hsync_a_i, vsync_a_i, hsync_b_i, vsync_b_i} = '0;
        {src_pin_i, lock_pin_i, sel_force_i, sel_reg_en_i, sel_reg_i} = '0;
        {mode_reg_en_i, mode_reg_i} = '0;
        {hpol_a_i, vpol_a_i, hpol_b_i, vpol_b_i} = 4'hF;
        miss_limit_i = 3'd2;
        line_period_i = 16'd20;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    // Active-high H pulses on a port: 2 cycles high, then low.
    task automatic lines(bit port_b, int n, int period);
        for (int i = 0; i < n; i++) begin
            if (port_b) hsync_b_i = 1; else hsync_a_i = 1;
            tick(2);
            if (port_b) hsync_b_i = 0; else hsync_a_i = 0;
            tick(period - 2);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ok", ref_ok_o, 0);
        chk("R1 lost", ref_lost_o, 1);
        chk("R1 mode", lock_mode_o, 0);
        chk("R1 port", port_sel_o, 0);
        h_cnt = 0;
        tick(10);
        chk("R1 no edges", h_cnt, 0);
    endtask

    task automatic t_select();
        do_reset();
        src_pin_i = 1;
        tick(2);
        chk("R2 pin latency early", port_sel_o, 0);
        tick(1);
        chk("R2 pin selects B", port_sel_o, 1);
        sel_reg_en_i = 1; sel_reg_i = 0;
        tick(2);
        chk("R2 reg enable overrides pin", port_sel_o, 0);
        sel_reg_en_i = 0; sel_force_i = 1; sel_reg_i = 1; src_pin_i = 0;
        tick(5);
        chk("R2 force uses reg bit", port_sel_o, 1);
    endtask

    task automatic t_mode();
        do_reset();
        lock_pin_i = 1; mode_reg_i = 0;
        tick(5);
        chk("R3 pin sets locked, reg bit ignored", lock_mode_o, 1);
        mode_reg_en_i = 1;
        tick(2);
        chk("R3 reg bit free run", lock_mode_o, 0);
        mode_reg_i = 1; lock_pin_i = 0;
        tick(5);
        chk("R3 reg bit locked", lock_mode_o, 1);
    endtask

    task automatic t_polarity();
        do_reset();
        hpol_a_i = 0; hsync_a_i = 1;
        tick(5);
        h_cnt = 0;
        hsync_a_i = 0;
        tick(2);
        chk("R4 no pulse before third edge", h_edge_o, 0);
        tick(1);
        chk("R4 active-low edge pulse", h_edge_o, 1);
        tick(1);
        chk("R4 pulse one cycle", h_edge_o, 0);
        hsync_a_i = 1;
        tick(6);
        chk("R4 inactive return no pulse", h_cnt, 1);
        v_cnt = 0;
        vsync_a_i = 1;
        tick(4);
        chk("R4 active-high V pulse", v_cnt, 1);
    endtask

    task automatic t_unselected();
        do_reset();
        h_cnt = 0; v_cnt = 0;
        lines(1, 3, 20);
        vsync_b_i = 1; tick(4); vsync_b_i = 0; tick(4);
        chk("R5 B ignored while A chosen (H)", h_cnt, 0);
        chk("R5 B ignored while A chosen (V)", v_cnt, 0);
        chk("R10 no pulses keeps ok low", ref_ok_o, 0);
        sel_reg_en_i = 1; sel_reg_i = 1;
        tick(2);
        vsync_b_i = 1; tick(5); vsync_b_i = 0;
        chk("R5 B V edge when chosen", v_cnt, 1);
    endtask

    task automatic t_qualify_and_loss(int lim, int early, int late);
        do_reset();
        miss_limit_i = 3'(lim);
        lines(0, 1, 20);
        chk("R6 one edge not enough", ref_ok_o, 0);
        lines(0, 2, 20);
        chk("R6 qualified after full line", ref_ok_o, 1);
        chk("R8 lost inverse", ref_lost_o, 0);
        tick(early);
        chk("R7 still good before limit", ref_ok_o, 1);
        tick(late - early);
        chk("R7 loss on limit+1 expiry", ref_ok_o, 0);
        chk("R8 lost inverse on loss", ref_lost_o, 1);
    endtask

    task automatic t_miss_clear();
        do_reset();
        miss_limit_i = 3'd1;
        lines(0, 3, 20);
        lines(0, 5, 40);
        chk("R7 edges clear miss count", ref_ok_o, 1);
    endtask

    task automatic t_port_change();
        do_reset();
        sel_reg_en_i = 1;
        lines(0, 3, 20);
        chk("R9 A qualified", ref_ok_o, 1);
        sel_reg_i = 1;
        tick(2);
        chk("R9 switch clears ok", ref_ok_o, 0);
        lines(1, 1, 20);
        chk("R9 one B edge not enough", ref_ok_o, 0);
        lines(1, 1, 20);
        chk("R9 B requalified", ref_ok_o, 1);
    endtask

    task automatic t_free_run_idle();
        do_reset();
        tick(120);
        chk("R10 idle ok low", ref_ok_o, 0);
        chk("R8 idle lost high", ref_lost_o, 1);
    endtask

    initial begin
        t_reset();
        t_select();
        t_mode();
        t_polarity();
        t_unselected();
        // last rise T0, return T0+20; limit 2 loss at T0+78
        t_qualify_and_loss(2, 45, 70);
        // limit 0 loss at T0+28
        t_qualify_and_loss(0, 0, 15);
        t_miss_clear();
        t_port_change();
        t_free_run_idle();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule